// File: doc/BRIEF.md
# I2C Short-Transaction Offload Sequencer

This block runs a complete short I2C transaction on behalf of software: one write, one read, or a write followed by a read. It does this with no software step per byte. Software fills two 32-bit transmit words and writes one control word. The sequencer then drives a byte-level bus engine through START, address, data, acknowledge and STOP steps. It issues one command at a time and waits for the engine's response before issuing the next. Received bytes are collected into two 32-bit receive words.

At completion the block sets an interrupt cause flag and records whether the transaction failed. A failure is a missing acknowledge on an address or a written byte, or a bus fault reported by the engine. The interrupt output follows the cause flag gated by a mask flag. Software clears the cause flag and the control word by writing zero to them. Each message carries between 1 and 8 bytes.

Top module: `i2c_offl_top`

## Requirements
- R1: Register select 0 is the control word: bit 0 requests a write phase, bit 1 a read phase, bits [11:2] the target address, bit 12 ten-bit addressing, bits [15:13] transmit count minus one, bits [18:16] receive count minus one, bit 19 launch, bit 20 repeated START. A control write with bit 19 set starts a transaction when the block is idle.
- R2: In seven-bit mode the address byte is {addr[6:0], dir}. In ten-bit mode two bytes are sent: {5'b11110, addr[9:8], dir} and then addr[7:0]. dir is 0 for a write phase and 1 for a read phase.
- R3: Engine commands are encoded 0 START, 1 repeated START, 2 write byte, 3 read byte, 4 STOP. A write phase sends START, the address, then count bytes taken little-endian from {select 2, select 1}, so byte 0 is select 1 bits [7:0].
- R4: A read phase stores bytes little-endian into {rx_hi, rx_lo}. Every received byte is acknowledged except the last, which is not. Receive lanes that are not filled read zero, because the receive words are cleared at launch.
- R5: When both phases are requested, bit 20 set puts a repeated START between them. With bit 20 clear the two phases are separated by a STOP and a fresh START.
- R6: Every transaction that reaches the bus ends with a STOP command.
- R7: A missing acknowledge on an address or written byte, or an engine fault on any step, is followed at once by STOP, and the transaction completes with the error bit set.
- R8: Completion sets cause. The error bit is cleared at each launch and holds the outcome of the last transaction. A write to select 3 loads cause from data bit 0.
- R9: irq is high exactly when both cause and mask are 1. A write to select 4 loads mask from data bit 0.
- R10: If completion and a software write of zero to cause fall in the same cycle, cause ends at 1.
- R11: A control write while a transaction is running is ignored: no second transaction starts, and the running command stream is unchanged.
- R12: A launch that requests neither phase issues no bus command, then completes with cause set and the error bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 ctrl, 1 tx low, 2 tx high, 3 cause, 4 mask) |
| reg_wdata | input | 32 | Register write data |
| rx_lo | output | 32 | Received bytes 0..3 |
| rx_hi | output | 32 | Received bytes 4..7 |
| err_status | output | 1 | Last transaction failed |
| cause | output | 1 | Completion cause flag |
| irq | output | 1 | Interrupt request |
| cmd_go | output | 1 | One-cycle command strobe to the byte engine |
| cmd_op | output | 3 | Engine command code |
| cmd_byte | output | 8 | Byte to send for write commands |
| cmd_give_ack | output | 1 | For read commands: acknowledge the byte |
| rsp_done | input | 1 | Engine finished the current command |
| rsp_acked | input | 1 | Target acknowledged the written byte |
| rsp_byte | input | 8 | Byte received by a read command |
| rsp_fault | input | 1 | Engine saw a bus fault |

## Verification
The sequencer's completion sets cause, and software can write cause in the same cycle. The bench forces this overlap. Its engine model answers the final STOP, and in the very next cycle, while the sequencer is in its finishing cycle, it injects a register write of zero to cause. The result is judged correct only if cause reads 1 and irq follows the mask afterwards.

// File: rtl/i2c_offl_pkg.sv
// Package: shared codes and control-word field positions for the offload sequencer.
package i2c_offl_pkg;
    // Control word fields (software-visible, so positions are fixed)
    localparam int CB_WR   = 0;
    localparam int CB_RD   = 1;
    localparam int CB_ADDR = 2;
    localparam int ADDR_W  = 10;
    localparam int CB_TEN  = 12;
    localparam int CB_TXN  = 13;
    localparam int CB_RXN  = 16;
    localparam int CB_GO   = 19;
    localparam int CB_REP  = 20;
    localparam int CTRL_W  = 21;

    // Register selects
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_TXLO  = 3'd1;
    localparam logic [2:0] SEL_TXHI  = 3'd2;
    localparam logic [2:0] SEL_CAUSE = 3'd3;
    localparam logic [2:0] SEL_MASK  = 3'd4;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_WRITE   = 3'd2,
        OP_READ    = 3'd3,
        OP_STOP    = 3'd4
    } eng_op_t;

    typedef enum logic [2:0] {
        K_START, K_ADDR1, K_ADDR2, K_WDATA, K_MID, K_RDATA, K_STOP
    } step_t;

    typedef enum logic [1:0] {
        P_IDLE, P_ISSUE, P_WAIT, P_FINISH
    } phase_t;
endpackage

// File: rtl/i2c_offl_addr.sv
// Address formatter: builds the first and second address bytes for
// seven-bit or ten-bit targets. Purely combinational; assumes the
// caller only uses `second` when ten-bit mode is selected.
module i2c_offl_addr #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] addr,
    input  logic          ten,
    input  logic          dir,
    output logic [7:0]    first,
    output logic [7:0]    second
);
    // Select the header form for ten-bit mode or the plain form
    always_comb begin
        if (ten) first = {5'b11110, addr[9:8], dir};
        else     first = {addr[6:0], dir};
        second = addr[7:0];
    end
endmodule

// File: rtl/i2c_offl_regs.sv
// Register bank: control, transmit words, cause, mask and error status.
// Registers a launch request one cycle so the sequencer sees a stable
// control word. Assumes fin is a one-cycle pulse from the sequencer.
module i2c_offl_regs #(
    parameter int BYTES = 8,
    localparam int W = 8 * BYTES
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_wr,
    input  logic [2:0]                        reg_sel,
    input  logic [31:0]                       reg_wdata,
    input  logic                              seq_busy,
    input  logic                              fin,
    input  logic                              fin_err,
    output logic [i2c_offl_pkg::CTRL_W-1:0]   ctrl_q,
    output logic [W-1:0]                      tx_q,
    output logic                              go_q,
    output logic                              err_q,
    output logic                              cause_q,
    output logic                              irq
);
    import i2c_offl_pkg::*;

    logic mask_q;
    logic busy_any;
    logic wr_ctrl;

    assign busy_any = seq_busy | go_q;
    assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL) && !busy_any;

    // Control word and launch strobe; writes while busy are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            go_q   <= 1'b0;
        end else begin
            go_q <= wr_ctrl && reg_wdata[CB_GO];
            if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
        end
    end

    // Transmit payload words, low word first in byte order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (reg_wr && reg_sel == SEL_TXLO) begin
            tx_q[31:0] <= reg_wdata;
        end else if (reg_wr && reg_sel == SEL_TXHI) begin
            tx_q[W-1:32] <= reg_wdata[W-33:0];
        end
    end

    // Cause flag: completion has priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)                             cause_q <= 1'b0;
        else if (fin)                           cause_q <= 1'b1;
        else if (reg_wr && reg_sel == SEL_CAUSE) cause_q <= reg_wdata[0];
    end

    // Mask flag
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= 1'b0;
        else if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata[0];
    end

    // Error status: cleared at launch, loaded at completion
    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (fin)  err_q <= fin_err;
        else if (go_q) err_q <= 1'b0;
    end

    assign irq = cause_q & mask_q;
endmodule

// File: rtl/i2c_offl_seq.sv
// Transaction sequencer: walks the write and/or read phase one engine
// command at a time (issue, then wait for the response), collects
// received bytes, and flags completion. Assumes the engine answers each
// command with exactly one rsp_done pulse, never before the command.
module i2c_offl_seq #(
    parameter int BYTES = 8,
    localparam int W = 8 * BYTES,
    localparam int CNT_W = $clog2(BYTES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             go,
    input  logic [i2c_offl_pkg::CTRL_W-1:0]  ctrl,
    input  logic [W-1:0]                     tx,
    input  logic                             rsp_done,
    input  logic                             rsp_acked,
    input  logic [7:0]                       rsp_byte,
    input  logic                             rsp_fault,
    output logic                             cmd_go,
    output logic [2:0]                       cmd_op,
    output logic [7:0]                       cmd_byte,
    output logic                             cmd_give_ack,
    output logic                             busy,
    output logic                             fin,
    output logic                             fin_err,
    output logic [W-1:0]                     rx
);
    import i2c_offl_pkg::*;

    phase_t             ph_q;
    step_t              step_q;
    logic               rd_ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               err_q;
    logic [7:0]         addr_first, addr_second;
    eng_op_t            op_c;
    step_t              after_addr;
    logic               bad;
    logic               rx_we;

    wire               do_wr   = ctrl[CB_WR];
    wire               do_rd   = ctrl[CB_RD];
    wire [ADDR_W-1:0]  addr    = ctrl[CB_ADDR +: ADDR_W];
    wire               ten     = ctrl[CB_TEN];
    wire [CNT_W-1:0]   tx_last = ctrl[CB_TXN +: CNT_W];
    wire [CNT_W-1:0]   rx_last = ctrl[CB_RXN +: CNT_W];
    wire               rep     = ctrl[CB_REP];

    i2c_offl_addr #(.AW(ADDR_W)) u_addr (
        .addr   (addr),
        .ten    (ten),
        .dir    (rd_ph_q),
        .first  (addr_first),
        .second (addr_second)
    );

    // Command presented to the engine for the current step
    always_comb begin
        op_c     = OP_STOP;
        cmd_byte = 8'h00;
        case (step_q)
            K_START: op_c = OP_START;
            K_ADDR1: begin op_c = OP_WRITE; cmd_byte = addr_first;  end
            K_ADDR2: begin op_c = OP_WRITE; cmd_byte = addr_second; end
            K_WDATA: begin op_c = OP_WRITE; cmd_byte = tx[cnt_q*8 +: 8]; end
            K_MID:   op_c = rep ? OP_RESTART : OP_STOP;
            K_RDATA: op_c = OP_READ;
            default: op_c = OP_STOP;
        endcase
    end

    assign cmd_go       = (ph_q == P_ISSUE);
    assign cmd_op       = op_c;
    assign cmd_give_ack = (step_q == K_RDATA) && (cnt_q != rx_last);
    assign after_addr   = rd_ph_q ? K_RDATA : K_WDATA;
    assign bad          = rsp_fault ||
                          (!rsp_acked && (step_q == K_ADDR1 || step_q == K_ADDR2 || step_q == K_WDATA));
    assign rx_we        = (ph_q == P_WAIT) && rsp_done && (step_q == K_RDATA) && !rsp_fault;

    // Phase and step progression of the transaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= P_IDLE;
            step_q  <= K_START;
            rd_ph_q <= 1'b0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (ph_q)
                P_IDLE: if (go) begin
                    err_q   <= 1'b0;
                    cnt_q   <= '0;
                    step_q  <= K_START;
                    rd_ph_q <= !do_wr;
                    ph_q    <= (do_wr || do_rd) ? P_ISSUE : P_FINISH;
                end
                P_ISSUE: ph_q <= P_WAIT;
                P_WAIT: if (rsp_done) begin
                    ph_q  <= P_ISSUE;
                    cnt_q <= '0;
                    if (step_q == K_STOP) begin
                        ph_q <= P_FINISH;
                        if (rsp_fault) err_q <= 1'b1;
                    end else if (bad) begin
                        step_q <= K_STOP;
                        err_q  <= 1'b1;
                    end else begin
                        case (step_q)
                            K_START: step_q <= K_ADDR1;
                            K_ADDR1: step_q <= ten ? K_ADDR2 : after_addr;
                            K_ADDR2: step_q <= after_addr;
                            K_WDATA:
                                if (cnt_q == tx_last) step_q <= do_rd ? K_MID : K_STOP;
                                else                  cnt_q  <= cnt_q + CNT_W'(1);
                            K_MID: begin
                                rd_ph_q <= 1'b1;
                                step_q  <= rep ? K_ADDR1 : K_START;
                            end
                            K_RDATA:
                                if (cnt_q == rx_last) step_q <= K_STOP;
                                else                  cnt_q  <= cnt_q + CNT_W'(1);
                            default: step_q <= K_STOP;
                        endcase
                    end
                end
                P_FINISH: ph_q <= P_IDLE;
                default:  ph_q <= P_IDLE;
            endcase
        end
    end

    // One receive lane per byte: cleared at launch, loaded on its turn
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                     lane_q <= 8'h00;
            else if (ph_q == P_IDLE && go)                  lane_q <= 8'h00;
            else if (rx_we && cnt_q == CNT_W'(i))           lane_q <= rsp_byte;
        end
        assign rx[i*8 +: 8] = lane_q;
    end

    assign busy    = (ph_q != P_IDLE);
    assign fin     = (ph_q == P_FINISH);
    assign fin_err = err_q;
endmodule

// File: rtl/i2c_offl_top.sv
// Top of the short-transaction offload sequencer: register bank plus
// sequencer driving a byte-level bus engine. Assumes one engine command
// outstanding at a time.
module i2c_offl_top #(
    parameter int BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] rx_lo,
    output logic [31:0] rx_hi,
    output logic        err_status,
    output logic        cause,
    output logic        irq,
    output logic        cmd_go,
    output logic [2:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    output logic        cmd_give_ack,
    input  logic        rsp_done,
    input  logic        rsp_acked,
    input  logic [7:0]  rsp_byte,
    input  logic        rsp_fault
);
    import i2c_offl_pkg::*;
    localparam int W = 8 * BYTES;

    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      tx_q, rx_q;
    logic              go_q, busy, fin, fin_err;

    i2c_offl_regs #(.BYTES(BYTES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .seq_busy  (busy),
        .fin       (fin),
        .fin_err   (fin_err),
        .ctrl_q    (ctrl_q),
        .tx_q      (tx_q),
        .go_q      (go_q),
        .err_q     (err_status),
        .cause_q   (cause),
        .irq       (irq)
    );

    i2c_offl_seq #(.BYTES(BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go_q),
        .ctrl         (ctrl_q),
        .tx           (tx_q),
        .rsp_done     (rsp_done),
        .rsp_acked    (rsp_acked),
        .rsp_byte     (rsp_byte),
        .rsp_fault    (rsp_fault),
        .cmd_go       (cmd_go),
        .cmd_op       (cmd_op),
        .cmd_byte     (cmd_byte),
        .cmd_give_ack (cmd_give_ack),
        .busy         (busy),
        .fin          (fin),
        .fin_err      (fin_err),
        .rx           (rx_q)
    );

    assign rx_lo = rx_q[31:0];
    assign rx_hi = rx_q[63:32];
endmodule

// File: rtl/i2c_offl_chk.sv
// Checker: protocol and completion properties observed at the top ports.
// Tracks the last issued command and whether a response is pending.
module i2c_offl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_go,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       cmd_give_ack,
    input logic       rsp_done,
    input logic       rsp_acked,
    input logic       rsp_fault,
    input logic       err_status,
    input logic       cause
);
    import i2c_offl_pkg::*;

    logic [2:0] op_q;
    logic       ack_q;
    logic       pend_q;

    // Remember the last command and whether its response is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= 3'd0;
            ack_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (cmd_go) begin
                op_q  <= cmd_op;
                ack_q <= cmd_give_ack;
            end
            if (cmd_go)        pend_q <= 1'b1;
            else if (rsp_done) pend_q <= 1'b0;
        end
    end

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> !pend_q);

    // R7
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_acked && op_q == OP_WRITE) |=> (cmd_go && cmd_op == OP_STOP));

    // R4
    last_read_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && op_q == OP_READ && !ack_q) |=> (cmd_go && cmd_op == OP_STOP));

    // R5
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_fault && op_q == OP_RESTART) |=> (cmd_go && cmd_op == OP_WRITE && cmd_byte[0]));

    // R8
    err_with_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status) |-> cause);
endmodule

bind i2c_offl_top i2c_offl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_go       (cmd_go),
    .cmd_op       (cmd_op),
    .cmd_byte     (cmd_byte),
    .cmd_give_ack (cmd_give_ack),
    .rsp_done     (rsp_done),
    .rsp_acked    (rsp_acked),
    .rsp_fault    (rsp_fault),
    .err_status   (err_status),
    .cause        (cause)
);

// File: tb/i2c_offl_top_bench.sv
// Scoreboard bench: tasks push the expected engine commands, an engine
// model pops and compares each command as the design issues it.
module i2c_offl_top_bench;
    localparam logic [2:0] E_START = 3'd0, E_RESTART = 3'd1, E_WRITE = 3'd2,
                           E_READ = 3'd3, E_STOP = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_wr = 1'b0;
    logic [2:0]  m_sel = 3'd0;
    logic [31:0] m_wd = 32'd0;
    logic        collide = 1'b0;
    logic        reg_wr;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] rx_lo, rx_hi;
    logic        err_status, cause, irq;
    logic        cmd_go, cmd_give_ack;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        rsp_done = 1'b0, rsp_acked = 1'b0, rsp_fault = 1'b0;
    logic [7:0]  rsp_byte = 8'h00;

    int checks = 0, fails = 0;
    int cmd_idx = 0, nack_idx = -1, fault_idx = -1, rd_ptr = 0;
    bit collide_en = 1'b0, col_next = 1'b0, finished = 1'b0;
    logic [7:0]  rd_src [8];
    logic [11:0] expq [$];

    always #5 clk = ~clk;

    assign reg_wr    = m_wr | collide;
    assign reg_sel   = collide ? 3'd3 : m_sel;
    assign reg_wdata = collide ? 32'd0 : m_wd;

    i2c_offl_top u_i2c_offl_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .rx_lo(rx_lo), .rx_hi(rx_hi), .err_status(err_status), .cause(cause), .irq(irq),
        .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_give_ack(cmd_give_ack),
        .rsp_done(rsp_done), .rsp_acked(rsp_acked), .rsp_byte(rsp_byte), .rsp_fault(rsp_fault)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_cmd(input logic [2:0] op, input logic ack, input logic [7:0] b);
        expq.push_back({op, ack, b});
    endtask

    task automatic wreg(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk); m_wr = 1'b1; m_sel = s; m_wd = d;
        @(negedge clk); m_wr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input bit wr, input bit rd, input logic [9:0] a,
                                       input bit ten, input int txn, input int rxn, input bit rep);
        logic [2:0] t = 3'(txn - 1);
        logic [2:0] r = 3'(rxn - 1);
        return {11'd0, rep, 1'b1, r, t, ten, a, rd, wr};
    endfunction

    // Engine model and monitor: compare each command, answer two cycles later
    initial begin
        int pend = 0;
        logic [11:0] got = '0;
        int my_idx = 0;
        forever begin
            @(negedge clk);
            rsp_done = 1'b0; rsp_fault = 1'b0;
            collide = col_next; col_next = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    rsp_done  = 1'b1;
                    rsp_acked = (my_idx != nack_idx);
                    rsp_fault = (my_idx == fault_idx);
                    if (got[11:9] == E_READ) begin rsp_byte = rd_src[rd_ptr]; rd_ptr++; end
                    if (got[11:9] == E_STOP && collide_en) col_next = 1'b1;
                end
            end
            if (rst_n && cmd_go) begin
                got = {cmd_op, cmd_give_ack, cmd_byte};
                my_idx = cmd_idx; cmd_idx++;
                pend = 2;
                if (expq.size() == 0) chk("R3 R11 unexpected command", 64'(got), 64'hFFF);
                else chk("R3 command stream", 64'(got), 64'(expq.pop_front()));
            end
        end
    end

    task automatic run(input string req, input logic [31:0] ctrl, input logic [31:0] lo,
                       input logic [31:0] hi, input logic [31:0] late,
                       input logic [31:0] exp_lo, input logic [31:0] exp_hi,
                       input bit exp_err, input bit exp_irq);
        int t = 0;
        cmd_idx = 0; rd_ptr = 0;
        wreg(3'd1, lo); wreg(3'd2, hi); wreg(3'd0, ctrl);
        if (late != 0) begin repeat (3) @(negedge clk); wreg(3'd0, late); end
        while (!cause && t < 2000) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        chk({req, " cause"}, 64'(cause), 64'd1);
        chk({req, " error"}, 64'(err_status), 64'(exp_err));
        chk({req, " irq"}, 64'(irq), 64'(exp_irq));
        chk({req, " rx"}, {rx_hi, rx_lo}, {exp_hi, exp_lo});
        chk({req, " leftover"}, 64'(expq.size()), 64'd0);
        expq.delete();
        wreg(3'd3, 32'd0); wreg(3'd0, 32'd0);
        nack_idx = -1; fault_idx = -1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rd_src[i] = 8'hA0 + 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 R9 reset state
        chk("R8 reset cause", 64'(cause), 64'd0);
        chk("R8 reset error", 64'(err_status), 64'd0);
        chk("R9 reset irq", 64'(irq), 64'd0);
        chk("R4 reset rx", {rx_hi, rx_lo}, 64'd0);
        chk("R3 reset cmd_go", 64'(cmd_go), 64'd0);
        wreg(3'd4, 32'd1);

        // R1 R3 R6 seven-bit write of three bytes
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'hA0);
        expect_cmd(E_WRITE,0,8'h11); expect_cmd(E_WRITE,0,8'h22); expect_cmd(E_WRITE,0,8'h33);
        expect_cmd(E_STOP,0,8'h00);
        run("R1/R3/R6 write", mk(1,0,10'h50,0,3,1,0), 32'h44332211, 0, 0, 0, 0, 0, 1);

        // R4 eight-byte read, last byte not acknowledged
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h47);
        for (int i = 0; i < 7; i++) expect_cmd(E_READ,1,8'h00);
        expect_cmd(E_READ,0,8'h00); expect_cmd(E_STOP,0,8'h00);
        run("R4 read8", mk(0,1,10'h23,0,1,8,0), 0, 0, 0, 32'hA3A2A1A0, 32'hA7A6A5A4, 0, 1);

        // R5 write-then-read with repeated START; R4 unused lanes zero
        for (int i = 0; i < 3; i++) rd_src[i] = 8'hC0 + 8'(i);
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h78);
        expect_cmd(E_WRITE,0,8'hA5); expect_cmd(E_WRITE,0,8'h5A);
        expect_cmd(E_RESTART,0,8'h00); expect_cmd(E_WRITE,0,8'h79);
        expect_cmd(E_READ,1,8'h00); expect_cmd(E_READ,1,8'h00); expect_cmd(E_READ,0,8'h00);
        expect_cmd(E_STOP,0,8'h00);
        run("R5/R4 restart", mk(1,1,10'h3C,0,2,3,1), 32'h00005AA5, 0, 0, 32'h00C2C1C0, 0, 0, 1);

        // R5 write-then-read separated by STOP and START
        rd_src[0] = 8'hD5;
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h78); expect_cmd(E_WRITE,0,8'hA5);
        expect_cmd(E_STOP,0,8'h00); expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h79);
        expect_cmd(E_READ,0,8'h00); expect_cmd(E_STOP,0,8'h00);
        run("R5 stop-start", mk(1,1,10'h3C,0,1,1,0), 32'h00005AA5, 0, 0, 32'h000000D5, 0, 0, 1);

        // R7 R9 address not acknowledged, mask off
        wreg(3'd4, 32'd0);
        nack_idx = 1;
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h22); expect_cmd(E_STOP,0,8'h00);
        run("R7/R9 addr nack", mk(1,0,10'h11,0,2,1,0), 32'h0000BEEF, 0, 0, 0, 0, 1, 0);
        wreg(3'd4, 32'd1);

        // R7 second data byte not acknowledged
        nack_idx = 3;
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'h22);
        expect_cmd(E_WRITE,0,8'h01); expect_cmd(E_WRITE,0,8'h02); expect_cmd(E_STOP,0,8'h00);
        run("R7 data nack", mk(1,0,10'h11,0,4,1,0), 32'h04030201, 0, 0, 0, 0, 1, 1);

        // R2 ten-bit write; R8 error cleared by the new launch
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'hF4); expect_cmd(E_WRITE,0,8'hB7);
        expect_cmd(E_WRITE,0,8'hA5); expect_cmd(E_STOP,0,8'h00);
        run("R2/R8 ten-bit", mk(1,0,10'h2B7,1,1,1,0), 32'h000000A5, 0, 0, 0, 0, 0, 1);

        // R7 engine fault on START
        fault_idx = 0;
        expect_cmd(E_START,0,8'h00); expect_cmd(E_STOP,0,8'h00);
        run("R7 fault", mk(0,1,10'h23,0,1,2,0), 0, 0, 0, 0, 0, 1, 1);

        // R11 control write during a running transaction is ignored
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'hA0);
        for (int i = 1; i <= 8; i++) expect_cmd(E_WRITE,0,8'(8'h11 * i));
        expect_cmd(E_STOP,0,8'h00);
        run("R11 busy write", mk(1,0,10'h50,0,8,1,0), 32'h44332211, 32'h88776655,
            mk(0,1,10'h23,0,1,1,0), 0, 0, 0, 1);

        // R12 launch with no phase requested
        run("R12 empty", 32'h00080000, 0, 0, 0, 0, 0, 0, 1);
        chk("R12 no commands", 64'(cmd_idx), 64'd0);

        // R10 completion and cause clear in the same cycle
        collide_en = 1'b1;
        expect_cmd(E_START,0,8'h00); expect_cmd(E_WRITE,0,8'hA0); expect_cmd(E_WRITE,0,8'h11);
        expect_cmd(E_STOP,0,8'h00);
        run("R10 collide", mk(1,0,10'h50,0,1,1,0), 32'h00000011, 0, 0, 0, 0, 0, 1);
        collide_en = 1'b0;

        // R9 mask off drops irq while cause stays set
        wreg(3'd3, 32'd1); wreg(3'd4, 32'd0);
        @(negedge clk);
        chk("R9 masked irq", 64'(irq), 64'd0);
        chk("R8 cause written", 64'(cause), 64'd1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule